// File: doc/BRIEF.md
# Source-Selectable Gated Peripheral Divider

This block produces a peripheral clock-enable stream in the fast system clock domain. It takes two incoming tick streams, one from a slow external reference and one from a PLL-derived source. The PLL stream can be used at full rate or pre-halved. When the PLL stream is selected, it passes through a programmable integer divider. When the external stream is selected, it bypasses the divider. A gate input stops the output, and a status output reports whether the clock is enabled.

If software changes the source while the clock is running, the block stops the output. It then waits until both sources have produced a settling number of ticks, moves to the new source, clears the divider and lets the output run again. If the clock is gated when the source changes, the change is committed on the next cycle. Divider updates never cut a period short, because the ratio is latched at the first counted tick of each period.

Top module: `clk_pdiv_gate`

## Requirements
- R1: After reset, `clk_en_o` and `running_o` are 0 and the external source is active.
- R2: While the external source is active (`src_pll_i` = 0 committed), the switch is idle and the gate is open, `clk_en_o` is high exactly in the cycle after each `ext_tick_i`, and `div_i` has no effect.
- R3: While the PLL source is active, `clk_en_o` pulses once per `div_i`+1 effective PLL ticks, one cycle after the tick that ends the period. A value of 0 passes every effective tick through, and the count starts from zero when a source change commits.
- R4: `pll_full_i` = 1 makes every `pll_tick_i` an effective tick. With `pll_full_i` = 0, only every second `pll_tick_i` is effective, and the parity is counted over all PLL ticks since reset, so the first tick after reset is skipped.
- R5: The divide ratio of a period is the `div_i` value sampled at the first effective tick of that period. A change in the middle of a period applies from the next period.
- R6: `gate_i` = 1 forces `clk_en_o` low in the next cycle, while the divider keeps counting.
- R7: A change of `src_pll_i` while ungated starts a switch. `clk_en_o` stays low from the second cycle after the request until one cycle after commit. Commit happens once at least SETTLE (default 2) external ticks and SETTLE effective PLL ticks have arrived after the switch starts.
- R8: A change of `src_pll_i` while `gate_i` = 1 commits in the next cycle without waiting for ticks.
- R9: `running_o` equals the inverse of `gate_i` from one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ext_tick_i | input | 1 | External reference tick (one-cycle pulse) |
| pll_tick_i | input | 1 | PLL-derived tick (one-cycle pulse) |
| src_pll_i | input | 1 | Source select: 1 = PLL-derived, 0 = external |
| pll_full_i | input | 1 | 1 = full PLL rate, 0 = half PLL rate |
| div_i | input | DIV_W | Divider field; the ratio is value + 1 |
| gate_i | input | 1 | 1 = clock stopped, 0 = clock running |
| clk_en_o | output | 1 | Output clock-enable pulse |
| running_o | output | 1 | Effective enable status |

## Verification
The bench targets a few corner cases:
- **Mid-period divider change.** A design that applied the new value at once would emit a short or long first period.
- **Half-rate parity across selection changes.** A design that reset the phase, or counted only while selected, would shift every pulse by one PLL tick.
- **Source switch while running.** A design that leaked the request-cycle pulse wrongly, or committed before both sources had settled, would show an extra pulse or an early restart.
- **Switch while gated.** A design that waited for ticks here would lose the first pulses once the gate opens.

// File: rtl/clk_pdiv_pkg.sv
package clk_pdiv_pkg;
  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_PLL = 1'b1
  } src_e;
endpackage

// File: rtl/clk_pdiv_halver.sv
module clk_pdiv_halver (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_tick_i,
  input  logic full_rate_i,
  output logic pll_eff_o
);
  logic ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (pll_tick_i) ph_d = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  assign pll_eff_o = pll_tick_i & (full_rate_i | ph_q);

  // R4: at half rate two consecutive PLL ticks are never both effective
  assert_half_alternate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_rate_i && pll_eff_o) |=> !(pll_eff_o && !full_rate_i && pll_tick_i));
endmodule

// File: rtl/clk_pdiv_counter.sv
module clk_pdiv_counter #(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tc_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] lat_q, lat_d;
  logic [DIV_W-1:0] lim;
  logic             at_start;
  logic             step;

  assign at_start = (cnt_q == '0);
  assign lim      = at_start ? div_i : lat_q;
  assign step     = adv_i & tick_i;
  assign tc_o     = step & (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    lat_d = lat_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (step) begin
      if (at_start) lat_d = div_i;
      if (cnt_q == lim) cnt_d = '0;
      else              cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lat_q <= lat_d;
    end
  end

  // R5: inside a period the count never passes the ratio latched at its start
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q <= lat_q));
  // R5: the latched ratio holds for the whole period
  assert_lat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !clr_i) |=> $stable(lat_q));
endmodule

// File: rtl/clk_pdiv_switch.sv
module clk_pdiv_switch
  import clk_pdiv_pkg::*;
#(
  parameter int SETTLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  src_e req_src_i,
  input  logic gate_i,
  input  logic ext_tick_i,
  input  logic pll_tick_i,
  output src_e act_src_o,
  output logic busy_o,
  output logic commit_o
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE);
  localparam logic [CW-1:0] ONE   = CW'(1);

  src_e          act_q, act_d;
  logic          busy_q, busy_d;
  logic [CW-1:0] ne_q, ne_d, np_q, np_d;
  logic          req, done;

  assign req  = (req_src_i != act_q);
  assign done = busy_q & (ne_q >= LIMIT) & (np_q >= LIMIT);

  always_comb begin
    act_d    = act_q;
    busy_d   = busy_q;
    ne_d     = ne_q;
    np_d     = np_q;
    commit_o = 1'b0;
    if (busy_q) begin
      if (done) begin
        commit_o = 1'b1;
        busy_d   = 1'b0;
        act_d    = req_src_i;
      end else begin
        if (ext_tick_i && ne_q < LIMIT) ne_d = ne_q + ONE;
        if (pll_tick_i && np_q < LIMIT) np_d = np_q + ONE;
      end
    end else if (req) begin
      if (gate_i) begin
        commit_o = 1'b1;
        act_d    = req_src_i;
      end else begin
        busy_d = 1'b1;
        ne_d   = '0;
        np_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= SRC_EXT;
      busy_q <= 1'b0;
      ne_q   <= '0;
      np_q   <= '0;
    end else begin
      act_q  <= act_d;
      busy_q <= busy_d;
      ne_q   <= ne_d;
      np_q   <= np_d;
    end
  end

  assign act_src_o = act_q;
  assign busy_o    = busy_q;

  // R7: the active source does not move while settling is incomplete
  assert_src_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> $stable(act_q));
  // R8: a gated request is committed in the next cycle
  assert_gated_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && req && gate_i) |=> (act_q == $past(req_src_i) && !busy_q));
endmodule

// File: rtl/clk_pdiv_gate.sv
module clk_pdiv_gate
  import clk_pdiv_pkg::*;
#(
  parameter int DIV_W       = 9,
  parameter int SETTLE      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_tick_i,
  input  logic             pll_tick_i,
  input  logic             src_pll_i,
  input  logic             pll_full_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             gate_i,
  output logic             clk_en_o,
  output logic             running_o
);
  logic rst_s;

  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic rs_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= 1'b0;
        else        rs_q <= 1'b1;
      end
      assign rst_s = rs_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] rs_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_s = rs_q[SYNC_STAGES-1];
    end
  endgenerate

  logic pll_eff;
  src_e act_src;
  logic busy, commit, tc;
  logic adv;
  logic raw;
  logic en_q, en_d, run_q, run_d;

  clk_pdiv_halver u_half (
    .clk        (clk),
    .rst_n      (rst_s),
    .pll_tick_i (pll_tick_i),
    .full_rate_i(pll_full_i),
    .pll_eff_o  (pll_eff)
  );

  clk_pdiv_switch #(.SETTLE(SETTLE)) u_sw (
    .clk       (clk),
    .rst_n     (rst_s),
    .req_src_i (src_e'(src_pll_i)),
    .gate_i    (gate_i),
    .ext_tick_i(ext_tick_i),
    .pll_tick_i(pll_eff),
    .act_src_o (act_src),
    .busy_o    (busy),
    .commit_o  (commit)
  );

  assign adv = (act_src == SRC_PLL) & ~busy;

  clk_pdiv_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_s),
    .adv_i (adv),
    .clr_i (commit),
    .tick_i(pll_eff),
    .div_i (div_i),
    .tc_o  (tc)
  );

  always_comb begin
    raw   = (act_src == SRC_PLL) ? tc : ext_tick_i;
    en_d  = raw & ~gate_i & ~busy;
    run_d = ~gate_i;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      en_q  <= 1'b0;
      run_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      run_q <= run_d;
    end
  end

  assign clk_en_o  = en_q;
  assign running_o = run_q;

  // R6: a closed gate silences the output on the next cycle
  assert_gate_off_R6: assert property (@(posedge clk) disable iff (!rst_s)
    gate_i |=> !clk_en_o);
  // R9: status follows the inverse of the gate
  assert_status_on_R9: assert property (@(posedge clk) disable iff (!rst_s)
    !gate_i |=> running_o);
  assert_status_off_R9: assert property (@(posedge clk) disable iff (!rst_s)
    gate_i |=> !running_o);
  // R7: no output pulse while a switch is settling
  assert_switch_quiet_R7: assert property (@(posedge clk) disable iff (!rst_s)
    busy |=> !clk_en_o);
  // R2: external ticks pass straight through when that source is active
  assert_ext_pass_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (act_src == SRC_EXT && !busy && !gate_i && ext_tick_i) |=> clk_en_o);
endmodule

// File: tb/clk_pdiv_gate_tb_top.sv
module clk_pdiv_gate_tb_top;
  localparam int DIV_W  = 9;
  localparam int SETTLE = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic ext_tick, pll_tick, src_pll, pll_full, gate;
  logic [DIV_W-1:0] div;
  logic clk_en, running;

  always #10 clk = ~clk;

  clk_pdiv_gate #(.DIV_W(DIV_W), .SETTLE(SETTLE)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_tick_i(ext_tick),
    .pll_tick_i(pll_tick),
    .src_pll_i (src_pll),
    .pll_full_i(pll_full),
    .div_i     (div),
    .gate_i    (gate),
    .clk_en_o  (clk_en),
    .running_o (running)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_ph, m_sel, m_busy;
  int m_cnt, m_ratio, m_ne, m_np;
  bit exp_en, exp_run;

  task automatic model_step();
    bit peff, adv, hit, req, done, commit;
    int lim;
    peff = pll_tick && (pll_full || m_ph);
    if (pll_tick) m_ph = !m_ph;
    adv  = !m_busy && m_sel;
    lim  = (m_cnt == 0) ? int'(div) : m_ratio;
    hit  = adv && peff && (m_cnt == lim);
    req  = (src_pll != m_sel);
    done = m_busy && m_ne >= SETTLE && m_np >= SETTLE;
    commit = done || (!m_busy && req && gate);
    exp_en  = (m_sel ? hit : ext_tick) && !gate && !m_busy;
    exp_run = !gate;
    if (commit) begin
      m_cnt = 0; m_sel = src_pll; m_busy = 0;
    end else begin
      if (adv && peff) begin
        if (m_cnt == 0) m_ratio = int'(div);
        if (hit) m_cnt = 0; else m_cnt++;
      end
      if (m_busy) begin
        if (ext_tick && m_ne < SETTLE) m_ne++;
        if (peff && m_np < SETTLE) m_np++;
      end else if (req) begin
        m_busy = 1; m_ne = 0; m_np = 0;
      end
    end
  endtask

  task automatic check(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  // one cycle: drive ticks at negedge, step model, compare at next negedge
  task automatic run(int n, int eper, int pper);
    for (int i = 0; i < n; i++) begin
      ext_tick = (eper == 0) ? 1'($urandom_range(1)) : (cyc % eper == 0);
      pll_tick = (pper == 0) ? 1'($urandom_range(1)) : (cyc % pper == 1 % pper);
      model_step();
      @(posedge clk);
      @(negedge clk);
      cyc++;
      check(cur_req, "clk_en_o", clk_en, exp_en);
      check(cur_req, "running_o", running, exp_run);
    end
  endtask

  initial begin
    rst_n = 1'b0; ext_tick = 0; pll_tick = 0; src_pll = 0; pll_full = 1;
    gate = 1; div = '0;
    m_ph = 0; m_sel = 0; m_busy = 0; m_cnt = 0; m_ratio = 0; m_ne = 0; m_np = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1", "clk_en_o after reset", clk_en, 0);
    check("R1", "running_o after reset", running, 0);

    // R2: external source passes through, divider ignored
    cur_req = "R2"; gate = 0; div = 9'd7;
    run(40, 3, 2);
    div = 9'd0; run(20, 4, 1);
    div = 9'd300; run(20, 0, 0);

    // R6 / R9: gate toggling
    cur_req = "R6";
    for (int k = 0; k < 40; k++) begin gate = 1'($urandom_range(1)); run(1, 2, 3); end
    cur_req = "R9"; gate = 1; run(3, 2, 2); gate = 0; run(3, 2, 2);

    // R7: switch to PLL while running, full rate, pass-through
    cur_req = "R7"; src_pll = 1; pll_full = 1; div = 9'd0;
    run(60, 5, 1);

    // R3: integer division on PLL source
    cur_req = "R3"; div = 9'd2; run(40, 5, 2);
    div = 9'd4; run(60, 5, 1);

    // R5: divider changes mid-period
    cur_req = "R5";
    for (int k = 0; k < 12; k++) begin div = 9'($urandom_range(5)); run(7, 5, 1); end

    // R4: half-rate PLL
    cur_req = "R4"; pll_full = 0; div = 9'd0; run(40, 5, 1);
    div = 9'd1; run(40, 5, 3);

    // R8: source change while gated
    cur_req = "R8"; gate = 1; src_pll = 0; run(3, 2, 1);
    gate = 0; run(20, 2, 1);
    gate = 1; src_pll = 1; run(3, 2, 1);
    gate = 0; div = 9'd1; pll_full = 1; run(30, 2, 1);

    // R7: switch back to external while running, slow external reference
    cur_req = "R7"; pll_full = 0; run(10, 9, 1);
    src_pll = 0; run(80, 9, 1);

    // mixed random operation
    cur_req = "R3";
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(9) == 0) src_pll = ~src_pll;
      if ($urandom_range(7) == 0) gate = 1'($urandom_range(3) == 0);
      if ($urandom_range(5) == 0) div = 9'($urandom_range(6));
      if ($urandom_range(11) == 0) pll_full = ~pll_full;
      run(5, 0, 0);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule